// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Page Latch

This block is the slave side of a two-wire serial bus. It fronts a 128-byte register memory and answers only to the fixed 7-bit device address 1010000. The clock and data lines arrive as plain levels and are sampled by the system clock. The data line is open-drain: the block pulls it low through one output and otherwise leaves it released. The block decodes START and STOP conditions, the control byte, a word address and data bytes. It serves byte writes, page writes of up to eight bytes, and current-address, random and sequential reads.

Write data is first collected in an eight-slot page latch. The latch is committed to the memory only when the master sends STOP, and then only after a timed busy period of `BUSY_CYCLES` system clocks. While that period runs the slave acknowledges nothing. A master can therefore poll with control bytes until one is acknowledged. A level input acts as write enable: it must stay high for the whole write transfer, or the STOP commits nothing.

Top module: `twi_nvm_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the ninth SCL high period) a control byte whose upper seven bits are 1010000, with bit 0 as read (1) or write (0). Any other control byte gets no acknowledge and SDA stays released.
- R2: In a write, the byte after the control byte loads the 7-bit address pointer, and every following data byte is acknowledged.
- R3: Data bytes go into an eight-slot page latch indexed by pointer bits [2:0]. After each byte only those three bits increment, modulo 8. Pointer bits [6:3] stay fixed, so a write that starts mid-page wraps to the page start.
- R4: When more than eight data bytes are sent in one write, the later bytes overwrite the earlier ones in the same slots, and only the last value per slot reaches memory.
- R5: Latched data is written to memory only on STOP, `BUSY_CYCLES` clocks after it. A repeated START discards the latched data of the write in progress.
- R6: While the busy period runs, the slave acknowledges no control byte, its own read or write address included.
- R7: If the write-enable input is low at any clock between the write control byte's acknowledge and STOP, the STOP commits nothing. Dropping the input after STOP does not stop the pending commit.
- R8: A current-address read returns the byte at the pointer, which is one past the last byte read or written.
- R9: A random read (write control byte, word address, repeated START, read control byte) returns the byte at that word address.
- R10: In a read, data is sent MSB first and changes only while SCL is low. A master acknowledge makes the slave send the next byte. A master no-acknowledge makes it release SDA.
- R11: During reads the full 7-bit pointer increments after each byte and wraps from 7Fh to 00h.
- R12: After reset SDA is released, the pointer is 00h, every memory byte reads 00h, and the slave is not busy.
- R13: START (SDA falling while SCL is high) restarts control-byte reception from any point. STOP (SDA rising while SCL is high) ends any transfer, releases SDA and leaves a half-received word address without effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level as seen on the wired bus |
| wrEnable | input | 1 | Write enable level; high allows a write transfer to commit |
| sdaLow | output | 1 | High pulls the open-drain data line low |

## Verification
The commit at the end of the busy period can fall in the same stretch of cycles as an acknowledge decision on a polling control byte. The bench sends polls back to back, starting right after STOP, so one poll lands close to the timer expiry. It then judges three things: the first poll is refused, a later one is accepted within a bounded number of tries, and memory read after that acceptance already holds the committed bytes. The same tension is tried with a read control byte sent straight after STOP, and with write enable dropped in the clock after STOP while the commit is still pending.

// File: rtl/twi_nvm_pkg.sv
package twi_nvm_pkg;

  // Strobes from the protocol control to the memory datapath.
  typedef struct packed {
    logic clearPage;  // new write transfer: empty the page latch
    logic loadPtr;    // word address received
    logic latchData;  // data byte received
    logic loadTx;     // byte handed to the transmitter, advance pointer
    logic commit;     // STOP of a valid write: start busy period
  } nvmStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACKOUT,
    ST_SEND,
    ST_ACKIN
  } busState_t;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_WORD,
    BK_DATA
  } byteKind_t;

endpackage

// File: rtl/twi_nvm_ctrl.sv
module twi_nvm_ctrl
  import twi_nvm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1010000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wrEnable,
  input  logic       busy,
  input  logic [7:0] txByte,
  output nvmStrobe_t strobe,
  output logic [7:0] rxByte,
  output logic       sdaLow
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_MSB-1:0], sclIn};
      sdaSync <= {sdaSync[SYNC_MSB-1:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_MSB];
  assign sdaS = sdaSync[SYNC_MSB];

  logic sclRise, sclFall, startEv, stopEv;
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;

  busState_t state;
  byteKind_t kind;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg, txShift;
  logic rwBit, writeTx, wpBad, dataSeen, masterAck;

  logic byteDone, devMatch, devAccept;
  assign byteDone  = (state == ST_RECV) && sclFall && (bitCnt == 4'd8);
  assign devMatch  = (shiftReg[7:1] == DEV_ADDR);
  assign devAccept = byteDone && (kind == BK_DEV) && devMatch && !busy;

  assign rxByte = shiftReg;

  always_comb begin
    strobe           = '0;
    strobe.clearPage = devAccept && !shiftReg[0];
    strobe.loadPtr   = byteDone && (kind == BK_WORD);
    strobe.latchData = byteDone && (kind == BK_DATA);
    strobe.loadTx    = ((state == ST_ACKOUT) && sclFall && (kind == BK_DEV) && rwBit)
                     || ((state == ST_ACKIN) && sclFall && masterAck);
    strobe.commit    = stopEv && writeTx && !wpBad && wrEnable && dataSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= BK_DEV;
      bitCnt    <= '0;
      shiftReg  <= '0;
      txShift   <= '0;
      rwBit     <= 1'b0;
      writeTx   <= 1'b0;
      masterAck <= 1'b0;
      sdaLow    <= 1'b0;
    end else if (startEv) begin
      state   <= ST_RECV;
      kind    <= BK_DEV;
      bitCnt  <= '0;
      sdaLow  <= 1'b0;
      writeTx <= 1'b0;
    end else if (stopEv) begin
      state   <= ST_IDLE;
      sdaLow  <= 1'b0;
      writeTx <= 1'b0;
    end else begin
      case (state)
        ST_RECV: begin
          if (sclRise && bitCnt != 4'd8) begin
            shiftReg <= {shiftReg[6:0], sdaS};
            bitCnt   <= bitCnt + 4'd1;
          end else if (byteDone) begin
            if (kind == BK_DEV) begin
              if (devAccept) begin
                sdaLow  <= 1'b1;
                state   <= ST_ACKOUT;
                rwBit   <= shiftReg[0];
                writeTx <= !shiftReg[0];
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sdaLow <= 1'b1;
              state  <= ST_ACKOUT;
            end
          end
        end
        ST_ACKOUT: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (kind == BK_DEV && rwBit) begin
              state   <= ST_SEND;
              txShift <= txByte;
              sdaLow  <= ~txByte[7];
            end else begin
              sdaLow <= 1'b0;
              state  <= ST_RECV;
              kind   <= (kind == BK_DEV) ? BK_WORD : BK_DATA;
            end
          end
        end
        ST_SEND: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              sdaLow <= 1'b0;
              state  <= ST_ACKIN;
              bitCnt <= '0;
            end else begin
              txShift <= {txShift[6:0], 1'b0};
              sdaLow  <= ~txShift[6];
              bitCnt  <= bitCnt + 4'd1;
            end
          end
        end
        ST_ACKIN: begin
          if (sclRise) begin
            masterAck <= ~sdaS;
          end else if (sclFall) begin
            if (masterAck) begin
              state   <= ST_SEND;
              txShift <= txByte;
              sdaLow  <= ~txByte[7];
              bitCnt  <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Write-enable watch and data presence for the write transfer in progress.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpBad    <= 1'b0;
      dataSeen <= 1'b0;
    end else begin
      if (strobe.clearPage) wpBad <= 1'b0;
      else if (writeTx && !wrEnable) wpBad <= 1'b1;
      if (strobe.clearPage) dataSeen <= 1'b0;
      else if (strobe.latchData) dataSeen <= 1'b1;
    end
  end

  AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACKOUT && kind == BK_DEV) |-> !busy); // R6
  AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLow) |-> $past(sclFall)); // R10
  AST_NO_TRAFFIC_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobe.loadTx || strobe.latchData || strobe.loadPtr)); // R6
  AST_RELEASE_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaLow); // R13

endmodule

// File: rtl/twi_nvm_dpath.sv
module twi_nvm_dpath
  import twi_nvm_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int PAGE_BYTES  = 8,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  nvmStrobe_t strobe,
  input  logic [7:0] rxByte,
  output logic [7:0] txByte,
  output logic       busy
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic [ADDR_W-1:0]       ptr;
  logic [BASE_W-1:0]       pageBase;
  logic [7:0]              mem [DEPTH];
  logic [PAGE_BYTES*8-1:0] pageFlat;
  logic [PAGE_BYTES-1:0]   pageValid;
  logic [BUSY_W-1:0]       busyCnt;

  // Page latch slots
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    logic [7:0] slotData;
    logic       slotValid;
    logic       hit;
    assign hit = strobe.latchData && (ptr[PAGE_W-1:0] == PAGE_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotData  <= '0;
        slotValid <= 1'b0;
      end else begin
        if (strobe.clearPage) slotValid <= 1'b0;
        else if (hit)         slotValid <= 1'b1;
        if (hit) slotData <= rxByte;
      end
    end
    assign pageFlat[g*8 +: 8] = slotData;
    assign pageValid[g]       = slotValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      pageBase <= '0;
    end else if (strobe.loadPtr) begin
      ptr <= rxByte[ADDR_W-1:0];
    end else if (strobe.latchData) begin
      pageBase <= ptr[ADDR_W-1:PAGE_W];
      ptr      <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
    end else if (strobe.loadTx) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (strobe.commit) begin
      busyCnt <= BUSY_W'(BUSY_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (busyCnt == BUSY_W'(1)) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pageValid[i]) mem[{pageBase, PAGE_W'(i)}] <= pageFlat[i*8 +: 8];
    end
  end

  assign txByte = mem[ptr];
  assign busy   = (busyCnt != '0);

  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strobe.commit)); // R5
  AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.commit); // R6
  AST_PAGE_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchData |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])); // R3
  AST_READ_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTx |=> ptr == ADDR_W'($past(ptr) + 1'b1)); // R11

endmodule

// File: rtl/twi_nvm_slave.sv
module twi_nvm_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b1010000,
  parameter int         ADDR_W      = 7,
  parameter int         PAGE_BYTES  = 8,
  parameter int         BUSY_CYCLES = 1000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wrEnable,
  output logic sdaLow
);

  twi_nvm_pkg::nvmStrobe_t strobe;
  logic [7:0] rxByte, txByte;
  logic       busy;

  twi_nvm_ctrl #(
    .DEV_ADDR    (DEV_ADDR),
    .SYNC_STAGES (SYNC_STAGES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .wrEnable (wrEnable),
    .busy     (busy),
    .txByte   (txByte),
    .strobe   (strobe),
    .rxByte   (rxByte),
    .sdaLow   (sdaLow)
  );

  twi_nvm_dpath #(
    .ADDR_W      (ADDR_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rxByte (rxByte),
    .txByte (txByte),
    .busy   (busy)
  );

endmodule

// File: tb/twi_nvm_slave_test.sv
`timescale 1ns/1ps
module twi_nvm_slave_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic wrEn = 1'b1;
  logic sdaLow;
  logic busSda;

  assign busSda = mSda & ~sdaLow;

  always #5 clk = ~clk;

  twi_nvm_slave #(.BUSY_CYCLES(400)) uut (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (scl),
    .sdaIn    (busSda),
    .wrEnable (wrEn),
    .sdaLow   (sdaLow)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] model [128];
  logic [6:0] mPtr = 7'd0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(4);
    scl = 1'b1;  tick(4);
    mSda = 1'b0; tick(4);
    scl = 1'b0;  tick(4);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(4);
    scl = 1'b1;  tick(4);
    mSda = 1'b1; tick(8);
  endtask

  task automatic sendBit(input logic b);
    mSda = b;   tick(4);
    scl = 1'b1; tick(4);
    scl = 1'b0; tick(4);
  endtask

  task automatic readBit(output logic b);
    mSda = 1'b1; tick(4);
    scl = 1'b1;  tick(2);
    b = busSda;  tick(2);
    scl = 1'b0;  tick(4);
  endtask

  task automatic sendByte(input logic [7:0] v, output int ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    readBit(b);
    ack = (b == 1'b0) ? 1 : 0;
  endtask

  task automatic recvByte(output logic [7:0] v, input bit giveAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    sendBit(giveAck ? 1'b0 : 1'b1);
  endtask

  // Reference page rule: low 3 bits wrap, upper 4 fixed
  task automatic modelWrite(input logic [6:0] a, input int n, input bit takes);
    logic [2:0] lo;
    for (int i = 0; i < n; i++) begin
      lo = 3'(a[2:0] + 3'(i));
      if (takes) model[{a[6:3], lo}] = wbuf[i];
    end
    mPtr = {a[6:3], 3'(a[2:0] + 3'(n))};
  endtask

  task automatic doWrite(input logic [6:0] a, input int n, output int nak);
    int ack;
    nak = 0;
    busStart();
    sendByte(8'hA0, ack); if (ack == 0) nak++;
    sendByte({1'b0, a}, ack); if (ack == 0) nak++;
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], ack);
      if (ack == 0) nak++;
    end
    busStop();
  endtask

  task automatic pollReady(output int tries);
    int ack;
    tries = 0;
    ack = 0;
    while (ack == 0 && tries < 40) begin
      tries++;
      busStart();
      sendByte(8'hA0, ack);
      busStop();
    end
  endtask

  task automatic readSeq(input bit useAddr, input logic [6:0] a, input int n, output int nak);
    int ack;
    nak = 0;
    busStart();
    if (useAddr) begin
      sendByte(8'hA0, ack); if (ack == 0) nak++;
      sendByte({1'b0, a}, ack); if (ack == 0) nak++;
      busStart();
      mPtr = a;
    end
    sendByte(8'hA1, ack); if (ack == 0) nak++;
    for (int i = 0; i < n; i++) recvByte(rbuf[i], i < n - 1);
    check(sdaLow == 1'b0, "R10 release after master nack", int'(sdaLow), 0);
    busStop();
  endtask

  task automatic cmpRead(input logic [6:0] a, input int n, input string req);
    for (int i = 0; i < n; i++)
      check(rbuf[i] == model[7'(a + 7'(i))], req, rbuf[i], model[7'(a + 7'(i))]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nak, tries, ack;
    logic [6:0] cur;
    logic [7:0] v;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(5);

    // R12: reset state
    check(sdaLow == 1'b0, "R12 sda released", int'(sdaLow), 0);
    readSeq(1'b0, 7'd0, 4, nak);
    check(nak == 0, "R12 read ack", nak, 0);
    cmpRead(7'd0, 4, "R12 memory cleared / R8 pointer at 0");
    mPtr = 7'd4;

    // R1: foreign control bytes ignored
    begin
      logic [7:0] wrong [4] = '{8'hA2, 8'hB0, 8'h20, 8'hE1};
      for (int i = 0; i < 4; i++) begin
        busStart(); sendByte(wrong[i], ack); busStop();
        check(ack == 0, "R1 foreign address nack", ack, 0);
      end
    end
    busStart(); sendByte(8'hA0, ack); busStop();
    check(ack == 1, "R1 own address ack", ack, 1);

    // R2/R6/R5: byte write and ack polling
    wbuf[0] = 8'h5A;
    doWrite(7'h23, 1, nak);
    check(nak == 0, "R2 write acks", nak, 0);
    pollReady(tries);
    check(tries >= 2, "R6 first poll refused", tries, 2);
    check(tries < 40, "R5 commit completes", tries, 39);
    modelWrite(7'h23, 1, 1'b1);
    readSeq(1'b1, 7'h23, 1, nak);
    check(nak == 0, "R9 random read acks", nak, 0);
    cmpRead(7'h23, 1, "R9 random read data");
    mPtr = 7'h24;
    readSeq(1'b0, 7'd0, 1, nak);
    cmpRead(7'h24, 1, "R8 current address read");
    mPtr = 7'h25;

    // R6: read control byte right after STOP is refused
    wbuf[0] = 8'hC3;
    doWrite(7'h10, 1, nak);
    busStart(); sendByte(8'hA1, ack); busStop();
    check(ack == 0, "R6 read refused while busy", ack, 0);
    pollReady(tries);
    modelWrite(7'h10, 1, 1'b1);
    readSeq(1'b1, 7'h10, 1, nak);
    cmpRead(7'h10, 1, "R5 byte after busy");

    // R3: page sweep over every start offset
    for (int s = 0; s < 8; s++) begin
      int n = (s % 4) + 3;
      for (int i = 0; i < n; i++) wbuf[i] = 8'(s * 16 + i + 1);
      doWrite(7'(8'h60 + s), n, nak);
      check(nak == 0, "R3 page write acks", nak, 0);
      pollReady(tries);
      modelWrite(7'(8'h60 + s), n, 1'b1);
      readSeq(1'b1, 7'h60, 8, nak);
      cmpRead(7'h60, 8, "R3 page wrap contents");
    end

    // R4: more than a page in one write
    for (int i = 0; i < 11; i++) wbuf[i] = 8'(8'h90 + i);
    doWrite(7'h52, 11, nak);
    check(nak == 0, "R4 overflow acks", nak, 0);
    pollReady(tries);
    modelWrite(7'h52, 11, 1'b1);
    readSeq(1'b1, 7'h50, 8, nak);
    cmpRead(7'h50, 8, "R4 overwrite order");

    // R7: write enable low for the whole transfer
    wrEn = 1'b0;
    for (int i = 0; i < 3; i++) wbuf[i] = 8'hE0 + 8'(i);
    doWrite(7'h30, 3, nak);
    wrEn = 1'b1;
    pollReady(tries);
    check(tries == 1, "R7 no busy when blocked", tries, 1);
    modelWrite(7'h30, 3, 1'b0);
    readSeq(1'b1, 7'h30, 3, nak);
    cmpRead(7'h30, 3, "R7 blocked write leaves memory");

    // R7: a short drop in the middle of data
    busStart();
    sendByte(8'hA0, ack); sendByte(8'h30, ack);
    sendByte(8'h11, ack);
    wrEn = 1'b0; tick(3); wrEn = 1'b1;
    sendByte(8'h22, ack);
    busStop();
    pollReady(tries);
    readSeq(1'b1, 7'h30, 2, nak);
    cmpRead(7'h30, 2, "R7 glitch blocks write");

    // R7: drop after STOP does not abort
    wbuf[0] = 8'h3C; wbuf[1] = 8'hA5;
    doWrite(7'h34, 2, nak);
    wrEn = 1'b0;
    pollReady(tries);
    wrEn = 1'b1;
    modelWrite(7'h34, 2, 1'b1);
    readSeq(1'b1, 7'h34, 2, nak);
    cmpRead(7'h34, 2, "R7 commit survives drop");

    // R11: pointer wrap in a sequential read
    wbuf[0] = 8'h7E; wbuf[1] = 8'h7F;
    doWrite(7'h7E, 2, nak); pollReady(tries); modelWrite(7'h7E, 2, 1'b1);
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    doWrite(7'h00, 2, nak); pollReady(tries); modelWrite(7'h00, 2, 1'b1);
    readSeq(1'b1, 7'h7E, 4, nak);
    cmpRead(7'h7E, 4, "R11 wrap 7F to 00");
    mPtr = 7'h02;
    readSeq(1'b0, 7'd0, 2, nak);
    cmpRead(7'h02, 2, "R10 sequential continues");

    // R5: repeated START discards latched data
    busStart();
    sendByte(8'hA0, ack); sendByte(8'h30, ack); sendByte(8'hEE, ack);
    busStart();
    sendByte(8'hA1, ack);
    recvByte(v, 1'b0);
    busStop();
    check(v == model[7'h31], "R5 pointer after latch", v, model[7'h31]);
    pollReady(tries);
    check(tries == 1, "R5 no commit without STOP", tries, 1);
    readSeq(1'b1, 7'h30, 1, nak);
    cmpRead(7'h30, 1, "R5 discarded on repeated START");

    // R13: START mid-byte restarts, STOP mid-address is harmless
    busStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStart();
    sendByte(8'hA1, ack);
    check(ack == 1, "R13 restart accepted", ack, 1);
    recvByte(v, 1'b0);
    busStop();
    check(v == model[7'h31], "R13 read after restart", v, model[7'h31]);
    busStart();
    sendByte(8'hA0, ack);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStop();
    check(sdaLow == 1'b0, "R13 released after stop", int'(sdaLow), 0);
    cur = 7'h32;
    readSeq(1'b0, 7'd0, 1, nak);
    cmpRead(cur, 1, "R13 pointer unchanged by partial address");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule